// File: doc/BRIEF.md
# SPI Interrupt Register Group

This block holds the interrupt registers of an SPI controller and sits on a simple synchronous register bus. It watches four conditions from the data path: a mode-fault pulse, the TX FIFO level against a programmable threshold, a TX-full level and an RX-not-empty level. It records them in a status register and combines them with an enable mask into one interrupt line. Software never writes the mask directly. A write to one address turns mask bits on, and a write to a second address turns them off. A third, read-only address returns the current mask.

Mode fault, TX-below-threshold and TX-full are sticky. Each stays set until software writes a one to its status bit. RX-not-empty is not sticky: it follows its input, delayed by one register, so it stays set while unread data remains. All register updates happen on the rising clock edge. Reads are combinational from the registers, and the interrupt output is combinational from the registers.

Top module: `spi_irq_regs`

## Requirements
- R1: After reset the status reads 0x00, the mask reads 0x00, the threshold reads 0x01 and irq is low.
- R2: A write to offset 0x08 sets each mask bit whose write-data bit is one and leaves the other mask bits unchanged.
- R3: A write to offset 0x0C clears each mask bit whose write-data bit is one and leaves the other mask bits unchanged.
- R4: The mask reads at offset 0x10. A write to 0x10 has no effect. Reads of offsets 0x08 and 0x0C, and reads while no read is selected, return zero.
- R5: A one-cycle pulse on ev_mode_fault sets status bit 1 at the next edge, and the bit stays set after the pulse ends.
- R6: A write to offset 0x04 clears each sticky status bit (bits 1 to 3) whose write-data bit is one. Zero bits in the write data leave status unchanged.
- R7: When an event and a write-one-to-clear of the same bit arrive in the same cycle, the bit ends up set.
- R8: The threshold register at offset 0x28 can be read and written. Status bit 2 sets at the next edge in any cycle where tx_level is strictly less than the threshold. It does not set when tx_level equals the threshold, and it stays set after tx_level rises again.
- R9: tx_full high in a cycle sets status bit 3 at the next edge, and the bit stays set until it is cleared.
- R10: Status bit 4 equals rx_nonempty as it was one cycle earlier. Writing one to bit 4 through offset 0x04 has no effect on it.
- R11: irq is high exactly when some bit is set in both the status and the mask.
- R12: Status bits 0, 5 and 6 always read as zero, even while every event is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte offset of the register |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Read data, combinational |
| ev_mode_fault | input | 1 | Mode-fault event pulse |
| tx_full | input | 1 | TX FIFO full level |
| rx_nonempty | input | 1 | RX FIFO not-empty level |
| tx_level | input | LVL_W (8) | Current TX FIFO fill level |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that a bus write lasts one cycle and targets a single offset. They also assume that every input is stable around the rising edge and that reset is applied from time zero. The stimulus meets this by changing every input only on the falling edge. Each access is held for exactly one cycle, and events are driven as one-cycle pulses or as levels held for whole cycles. Cases where two things coincide, such as an event together with a clear, or a level equal to the threshold, are set up on purpose on that same falling edge.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int IRQ_W      = 7;
  localparam int BIT_MODF   = 1;
  localparam int BIT_TXWM   = 2;
  localparam int BIT_TXFULL = 3;
  localparam int BIT_RXNE   = 4;

  localparam int OFS_STAT = 'h04;
  localparam int OFS_MSET = 'h08;
  localparam int OFS_MCLR = 'h0C;
  localparam int OFS_MASK = 'h10;
  localparam int OFS_WM   = 'h28;

  typedef struct packed {
    logic stat_clr;
    logic mask_set;
    logic mask_clr;
    logic wm_wr;
  } strobes_t;

  // sticky bits are the ones cleared by write-one
  function automatic logic is_sticky(input int b);
    return (b == BIT_MODF) || (b == BIT_TXWM) || (b == BIT_TXFULL);
  endfunction

  function automatic logic [IRQ_W-1:0] ev_pack(input logic modf,
                                               input logic wm,
                                               input logic full);
    logic [IRQ_W-1:0] v;
    v = '0;
    v[BIT_MODF]   = modf;
    v[BIT_TXWM]   = wm;
    v[BIT_TXFULL] = full;
    return v;
  endfunction

  // set wins over clear
  function automatic logic sticky_next(input logic cur, input logic clr,
                                       input logic set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [IRQ_W-1:0] mask_next(input logic [IRQ_W-1:0] cur,
                                                 input logic [IRQ_W-1:0] bits,
                                                 input logic do_set,
                                                 input logic do_clr);
    logic [IRQ_W-1:0] n;
    n = cur;
    if (do_set) n = n | bits;
    if (do_clr) n = n & ~bits;
    return n;
  endfunction

  function automatic logic irq_any(input logic [IRQ_W-1:0] stat,
                                   input logic [IRQ_W-1:0] mask);
    return |(stat & mask);
  endfunction
endpackage

// File: rtl/spi_irq_decode.sv
module spi_irq_decode
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int LVL_W  = 8
) (
  input  logic              sel,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IRQ_W-1:0]  stat,
  input  logic [IRQ_W-1:0]  mask,
  input  logic [LVL_W-1:0]  thr,
  output strobes_t          strb,
  output logic [DATA_W-1:0] rdata
);
  logic hit_stat, hit_mset, hit_mclr, hit_mask, hit_wm;
  logic do_wr, do_rd;

  assign hit_stat = (addr == ADDR_W'(OFS_STAT));
  assign hit_mset = (addr == ADDR_W'(OFS_MSET));
  assign hit_mclr = (addr == ADDR_W'(OFS_MCLR));
  assign hit_mask = (addr == ADDR_W'(OFS_MASK));
  assign hit_wm   = (addr == ADDR_W'(OFS_WM));
  assign do_wr    = sel & write;
  assign do_rd    = sel & ~write;

  assign strb.stat_clr = do_wr & hit_stat;
  assign strb.mask_set = do_wr & hit_mset;
  assign strb.mask_clr = do_wr & hit_mclr;
  assign strb.wm_wr    = do_wr & hit_wm;

  always_comb begin
    rdata = '0;
    if (do_rd) begin
      if (hit_stat)      rdata = DATA_W'(stat);
      else if (hit_mask) rdata = DATA_W'(mask);
      else if (hit_wm)   rdata = DATA_W'(thr);
    end
  end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic [IRQ_W-1:0] clr_bits,
  input  logic             ev_modf,
  input  logic             tx_full,
  input  logic             rx_ne,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] thr,
  output logic [IRQ_W-1:0] stat,
  output logic             wm_hit
);
  logic [IRQ_W-1:0] set_vec;

  assign wm_hit  = (tx_level < thr);
  assign set_vec = ev_pack(ev_modf, wm_hit, tx_full);

  for (genvar b = 0; b < IRQ_W; b++) begin : g_bit
    if (b == BIT_RXNE) begin : g_live
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= 1'b0;
        else        r <= rx_ne;
      end
      assign stat[b] = r;
    end else if (is_sticky(b)) begin : g_stk
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= 1'b0;
        else        r <= sticky_next(r, clr_en & clr_bits[b], set_vec[b]);
      end
      assign stat[b] = r;
    end else begin : g_rsv
      assign stat[b] = 1'b0;
    end
  end
endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask
  import spi_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [IRQ_W-1:0] bits,
  output logic [IRQ_W-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= mask_next(mask, bits, set_en, clr_en);
  end
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int LVL_W    = 8,
  parameter int WM_RESET = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_mode_fault,
  input  logic              tx_full,
  input  logic              rx_nonempty,
  input  logic [LVL_W-1:0]  tx_level,
  output logic              irq
);
  strobes_t         strb;
  logic [IRQ_W-1:0] stat_q;
  logic [IRQ_W-1:0] mask_q;
  logic [LVL_W-1:0] thr_q;
  logic [IRQ_W-1:0] wbits;
  logic             wm_hit;

  assign wbits = bus_wdata[IRQ_W-1:0];

  spi_irq_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_dec (
    .sel(bus_sel), .write(bus_write), .addr(bus_addr),
    .stat(stat_q), .mask(mask_q), .thr(thr_q),
    .strb(strb), .rdata(bus_rdata)
  );

  spi_irq_status #(.LVL_W(LVL_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .clr_en(strb.stat_clr), .clr_bits(wbits),
    .ev_modf(ev_mode_fault), .tx_full(tx_full), .rx_ne(rx_nonempty),
    .tx_level(tx_level), .thr(thr_q), .stat(stat_q), .wm_hit(wm_hit)
  );

  spi_irq_mask u_mask (
    .clk(clk), .rst_n(rst_n), .set_en(strb.mask_set), .clr_en(strb.mask_clr),
    .bits(wbits), .mask(mask_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         thr_q <= LVL_W'(WM_RESET);
    else if (strb.wm_wr) thr_q <= bus_wdata[LVL_W-1:0];
  end

  assign irq = irq_any(stat_q, mask_q);
endmodule

// File: rtl/spi_irq_regs_chk.sv
module spi_irq_regs_chk
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int LVL_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              ev_mode_fault,
  input logic              tx_full,
  input logic              rx_nonempty,
  input logic [LVL_W-1:0]  tx_level,
  input logic              irq,
  input logic [4:1]        stat_act,
  input logic [6:0]        mask_q,
  input logic [LVL_W-1:0]  thr_q,
  input logic              wm_hit
);
  logic wr_set, wr_clr, wr_stat, wr_wm, rd_stat;
  assign wr_set  = bus_sel && bus_write && (bus_addr == ADDR_W'('h08));
  assign wr_clr  = bus_sel && bus_write && (bus_addr == ADDR_W'('h0C));
  assign wr_stat = bus_sel && bus_write && (bus_addr == ADDR_W'('h04));
  assign wr_wm   = bus_sel && bus_write && (bus_addr == ADDR_W'('h28));
  assign rd_stat = bus_sel && !bus_write && (bus_addr == ADDR_W'('h04));

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((mask_q & $past(bus_wdata[6:0])) == $past(bus_wdata[6:0]))); // R2
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((mask_q & $past(bus_wdata[6:0])) == 7'h00)); // R3
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_set && !wr_clr) |=> $stable(mask_q)); // R4
  AST_MODF_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mode_fault |=> stat_act[1]); // R7
  AST_MODF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[1] && !ev_mode_fault) |=> !stat_act[1]); // R6
  AST_WM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level < thr_q) |=> stat_act[2]); // R8
  AST_WM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wm_hit |=> stat_act[2]); // R8
  AST_WM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wm |=> (thr_q == $past(bus_wdata[LVL_W-1:0]))); // R8
  AST_FULL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |=> stat_act[3]); // R9
  AST_RX_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (stat_act[4] == $past(rx_nonempty))); // R10
  AST_IRQ_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_act[1] && mask_q[1]) |-> irq); // R11
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 7'h00) |-> !irq); // R11
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |-> ((bus_rdata & DATA_W'(8'hE1)) == '0)); // R12
endmodule

bind spi_irq_regs spi_irq_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .ev_mode_fault(ev_mode_fault), .tx_full(tx_full), .rx_nonempty(rx_nonempty),
  .tx_level(tx_level), .irq(irq), .stat_act(stat_q[4:1]), .mask_q(mask_q),
  .thr_q(thr_q), .wm_hit(wm_hit)
);

// File: tb/spi_irq_regs_bench.sv
`timescale 1ns/1ps
module spi_irq_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_write = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ev_mode_fault = 1'b0, tx_full = 1'b0, rx_nonempty = 1'b0;
  logic [7:0] tx_level = 8'd8;
  logic       irq;

  int total = 0, bad = 0;
  int ms = 0, mm = 0, mt = 1;
  bit done = 0;

  always #4 clk = ~clk;

  spi_irq_regs u_spi_irq_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_mode_fault(ev_mode_fault), .tx_full(tx_full), .rx_nonempty(rx_nonempty),
    .tx_level(tx_level), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    int setv, nst;
    if (!rst_n) begin
      ms = 0; mm = 0; mt = 1;
    end else begin
      setv = 0;
      if (ev_mode_fault) setv |= 2;
      if (int'(tx_level) < mt) setv |= 4;
      if (tx_full) setv |= 8;
      nst = ms;
      if (bus_sel && bus_write && bus_addr == 6'h04) nst &= ~int'(bus_wdata);
      nst = ((nst | setv) & 'h0E) | (rx_nonempty ? 'h10 : 0);
      ms = nst;
      if (bus_sel && bus_write && bus_addr == 6'h08) mm |= int'(bus_wdata) & 'h7F;
      if (bus_sel && bus_write && bus_addr == 6'h0C) mm &= ~int'(bus_wdata);
      if (bus_sel && bus_write && bus_addr == 6'h28) mt = int'(bus_wdata);
    end
  end

  function automatic int model_read();
    if (!(bus_sel && !bus_write)) return 0;
    case (bus_addr)
      6'h04: return ms;
      6'h10: return mm;
      6'h28: return mt;
      default: return 0;
    endcase
  endfunction

  // per-cycle comparison against the reference
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R11 model irq", int'(irq), ((ms & mm) != 0) ? 1 : 0);
      check("R4 model rdata", int'(bus_rdata), model_read());
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [5:0] a, input int exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_write = 0; bus_addr = a;
    #1;
    check(tag, int'(bus_rdata), exp);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic chk_irq(input int exp, input string tag);
    @(negedge clk); #1;
    check(tag, int'(irq), exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(6'h04, 'h00, "R1 status after reset");
    rd(6'h10, 'h00, "R1 mask after reset");
    rd(6'h28, 'h01, "R1 threshold after reset");
    chk_irq(0, "R1 irq after reset");
    // R2 set
    wr(6'h08, 8'h16); rd(6'h10, 'h16, "R2 mask set");
    wr(6'h08, 8'h01); rd(6'h10, 'h17, "R2 mask set keeps others");
    // R3 clear
    wr(6'h0C, 8'h06); rd(6'h10, 'h11, "R3 mask clear");
    // R4 mask read-only, write-only regs read zero
    wr(6'h10, 8'h7F); rd(6'h10, 'h11, "R4 mask write ignored");
    rd(6'h08, 'h00, "R4 enable reads zero");
    rd(6'h0C, 'h00, "R4 disable reads zero");
    // R5 mode fault
    @(negedge clk); ev_mode_fault = 1; @(negedge clk); ev_mode_fault = 0;
    rd(6'h04, 'h02, "R5 mode fault latched");
    repeat (3) @(negedge clk);
    rd(6'h04, 'h02, "R5 mode fault sticky");
    chk_irq(0, "R11 masked source no irq");
    wr(6'h08, 8'h02);
    chk_irq(1, "R11 enabled source irq");
    // R6 write-one-to-clear
    wr(6'h04, 8'h00); rd(6'h04, 'h02, "R6 zero write no effect");
    wr(6'h04, 8'h02); rd(6'h04, 'h00, "R6 clear by one");
    chk_irq(0, "R11 irq drops after clear");
    // R7 priority
    @(negedge clk);
    bus_sel = 1; bus_write = 1; bus_addr = 6'h04; bus_wdata = 8'h02; ev_mode_fault = 1;
    @(negedge clk);
    bus_sel = 0; bus_write = 0; ev_mode_fault = 0;
    rd(6'h04, 'h02, "R7 event beats clear");
    wr(6'h04, 8'h02);
    // R8 watermark
    wr(6'h28, 8'h04); rd(6'h28, 'h04, "R8 threshold readback");
    @(negedge clk); tx_level = 8'd4;
    rd(6'h04, 'h00, "R8 level equal no event");
    @(negedge clk); tx_level = 8'd3;
    rd(6'h04, 'h04, "R8 level below sets");
    @(negedge clk); tx_level = 8'd9;
    rd(6'h04, 'h04, "R8 sticky after rise");
    wr(6'h04, 8'h04); rd(6'h04, 'h00, "R8 cleared");
    // R9 tx full
    @(negedge clk); tx_full = 1; @(negedge clk); tx_full = 0;
    rd(6'h04, 'h08, "R9 full latched");
    wr(6'h04, 8'h08); rd(6'h04, 'h00, "R9 cleared");
    // R10 rx live
    @(negedge clk); rx_nonempty = 1;
    rd(6'h04, 'h10, "R10 rx set");
    wr(6'h04, 8'h10); rd(6'h04, 'h10, "R10 clear ignored");
    chk_irq(1, "R11 rx enabled irq");
    @(negedge clk); rx_nonempty = 0;
    rd(6'h04, 'h00, "R10 rx follows input");
    // R12 reserved bits
    wr(6'h08, 8'h7F);
    @(negedge clk); ev_mode_fault = 1; tx_full = 1; rx_nonempty = 1; tx_level = 8'd0;
    @(negedge clk); ev_mode_fault = 0;
    rd(6'h04, 'h1E, "R12 reserved bits zero");
    chk_irq(1, "R11 all sources irq");
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule